// File: doc/BRIEF.md
# Linked-Descriptor Display Fetch Engine

This block feeds a display controller with pixel and colour-table words taken from memory. Software builds a chain of four-word descriptors in memory and pulses `start` with the byte address of the first one. The engine reads that descriptor, then streams the region it names into an internal FIFO. Each stored word is tagged as either colour-table data or pixel data. It then moves to the descriptor named by the next-pointer word, and it does this with no end. A chain that alternates a colour-table descriptor with a frame descriptor reloads the table before every frame. A frame descriptor whose next pointer names itself repeats that frame for as long as the engine runs.

Memory is reached through a word-addressed read port. A request carries a word address and a beat count, and it is held until granted. The granted beats then return in order, one per `mem_rvalid`. A data request is never longer than `BURST` words, and it is not issued until the FIFO has room for the whole request. The display side pops words with `pix_rd`. When the FIFO is empty and underrun protection is on, the engine keeps presenting the last word it handed out and records the event in a sticky flag instead of withdrawing `pix_valid`. A second descriptor pointer, used by a dual-panel setup, is only captured and presented.

The control FSM has five states. From IDLE, `start` leads to DESC_REQ. The FSM leaves DESC_REQ for DESC_RCV when the four-beat descriptor read is granted. After the command word arrives in DESC_RCV, it goes to DATA_REQ, or straight back to DESC_REQ for a zero-length transfer. DATA_REQ goes to DATA_RCV once a data burst is granted. After the last beat of a burst, DATA_RCV returns to DATA_REQ while words remain, and goes to DESC_REQ (next pointer) once the transfer is complete. A `start` in any state goes to DESC_REQ and empties the FIFO.

Top module: `fb_dma_fetch`

## Requirements
- R1: After reset and before any `start`, `mem_req`, `pix_valid`, `underrun` and `desc_done` are low and `frame_id` is 0.
- R2: A `start` empties the FIFO and begins a four-beat read at word address `desc_ptr0[31:2]`. The four beats are taken in this order: next-descriptor byte address, source byte address, frame ID, command.
- R3: Command bits 23:0 give the transfer length in 32-bit words. Every other command bit except bit 28 is ignored. Data is read from consecutive word addresses starting at source bits [31:2], in requests of 1 to `BURST` (16) beats.
- R4: Command bit 28 set marks every word of that transfer as colour-table data (`pix_pal`=1); bit 28 clear gives `pix_pal`=0.
- R5: After a transfer's last word, the next descriptor is read from the captured next pointer. A descriptor that points to itself repeats the same data indefinitely.
- R6: A zero-length descriptor requests no data and is followed directly by the read of its next descriptor.
- R7: `frame_id` takes a descriptor's frame ID when its command word arrives, zero-length descriptors included, and holds it until the next descriptor's command word.
- R8: `desc_done` is a one-cycle pulse in the cycle the last word of a non-empty transfer is written into the FIFO. Zero-length descriptors give no pulse.
- R9: A data request is raised only when the FIFO has free room for its full beat count. Any request is held with a stable address and length until `mem_gnt`, so the FIFO never overflows.
- R10: Words leave in the order they were fetched. `pix_valid` is high while the FIFO holds data, and `pix_rd` pops one word.
- R11: With `ur_protect`=1 and the FIFO empty, `pix_valid` stays high and `pix_data`/`pix_pal` repeat the last popped word. A `pix_rd` in that condition sets `underrun`, which only the next `start` clears.
- R12: With `ur_protect`=0 and the FIFO empty, `pix_valid` is low and `pix_rd` leaves `underrun` unchanged.
- R13: `dual_ptr` captures `desc_ptr1` on each `start` and holds it otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch/restart the chain walk |
| desc_ptr0 | input | ADDR_W | Byte address of the first descriptor |
| desc_ptr1 | input | ADDR_W | Second-panel descriptor pointer, captured only |
| ur_protect | input | 1 | Underrun protection enable |
| mem_req | output | 1 | Read request valid |
| mem_addr | output | ADDR_W-2 | Request word address |
| mem_len | output | $clog2(BURST+1) | Request beat count |
| mem_gnt | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Read beat valid |
| mem_rdata | input | 32 | Read beat data |
| pix_rd | input | 1 | Pop one output word |
| pix_valid | output | 1 | Output word available |
| pix_data | output | 32 | Output word |
| pix_pal | output | 1 | Output word is colour-table data |
| underrun | output | 1 | Sticky empty-read flag |
| frame_id | output | 32 | Frame ID of the current descriptor |
| desc_done | output | 1 | Transfer-complete pulse |
| dual_ptr | output | ADDR_W | Captured second-panel pointer |

## Verification
The `start` restart can coincide with a data beat that is still arriving from the previous chain. The bench provokes this by switching from the self-looping chain to the alternating chain while the engine is still fetching. It judges the result by checking that the first words popped afterwards come only from the new chain's colour table. The same restart also places an empty-FIFO pop against underrun protection. The bench judges it by checking that the repeated word equals the last word popped before the restart and that the sticky flag survives until the following `start`.

// File: rtl/fbd_pkg.sv
package fbd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DESC_REQ,
        ST_DESC_RCV,
        ST_DATA_REQ,
        ST_DATA_RCV
    } fbd_state_e;

    localparam int DESC_BEATS = 4;
    localparam int PAL_FLAG_BIT = 28;

endpackage

// File: rtl/fbd_fifo.sv
module fbd_fifo #(
    parameter int W = 33,
    parameter int DEPTH = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr,
    input  logic [W-1:0]     wdata,
    input  logic             rd,
    output logic [W-1:0]     rdata,
    output logic             empty,
    output logic [CNT_W-1:0] free
);

    logic [W-1:0]     store [DEPTH];
    logic [PTR_W-1:0] wp, rp;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else if (clr) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (wr) wp <= wp + PTR_W'(1);
            if (rd) rp <= rp + PTR_W'(1);
            cnt <= cnt + CNT_W'(wr) - CNT_W'(rd);
        end
    end

    always_ff @(posedge clk) begin
        if (wr && !clr) store[wp] <= wdata;
    end

    assign rdata = store[rp];
    assign empty = (cnt == '0);
    assign free  = CNT_W'(DEPTH) - cnt;

endmodule

// File: rtl/fbd_ctrl.sv
module fbd_ctrl
    import fbd_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W = 24,
    parameter int BURST = 16,
    parameter int CNT_W = 6,
    localparam int BL_W = $clog2(BURST + 1),
    localparam int WA_W = ADDR_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_ptr,
    output logic              mem_req,
    output logic [WA_W-1:0]   mem_addr,
    output logic [BL_W-1:0]   mem_len,
    input  logic              mem_gnt,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    input  logic [CNT_W-1:0]  fifo_free,
    output logic              wr_en,
    output logic [32:0]       wr_word,
    output logic              clr,
    output logic [31:0]       frame_id,
    output logic              desc_done
);

    fbd_state_e state, state_nx;

    logic [WA_W-1:0]  cur_ptr;
    logic [WA_W-1:0]  nxt_ptr;
    logic [WA_W-1:0]  src;
    logic [LEN_W-1:0] rem;
    logic             pal;
    logic [31:0]      id_hold;
    logic [BL_W-1:0]  beat;
    logic [BL_W-1:0]  burst_len;
    logic [BL_W-1:0]  blen;
    logic             room;
    logic             go;
    logic             desc_last;
    logic             data_last;
    logic             zero_len;
    logic             xfer_end;

    // Burst size for the next data request
    assign blen = (rem > LEN_W'(BURST)) ? BL_W'(BURST) : rem[BL_W-1:0];
    assign room = (fifo_free >= CNT_W'(blen));
    assign go   = mem_req && mem_gnt;

    assign desc_last = (state == ST_DESC_RCV) && mem_rvalid && (beat == BL_W'(DESC_BEATS - 1));
    assign zero_len  = (mem_rdata[LEN_W-1:0] == '0);
    assign data_last = (state == ST_DATA_RCV) && mem_rvalid && (beat == burst_len - BL_W'(1));
    assign xfer_end  = (rem == LEN_W'(1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        if (start) begin
            state_nx = ST_DESC_REQ;
        end else begin
            unique case (state)
                ST_IDLE:     state_nx = ST_IDLE;
                ST_DESC_REQ: if (go) state_nx = ST_DESC_RCV;
                ST_DESC_RCV: if (desc_last) state_nx = zero_len ? ST_DESC_REQ : ST_DATA_REQ;
                ST_DATA_REQ: if (go) state_nx = ST_DATA_RCV;
                ST_DATA_RCV: if (data_last) state_nx = xfer_end ? ST_DESC_REQ : ST_DATA_REQ;
                default:     state_nx = ST_IDLE;
            endcase
        end
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_ptr   <= '0;
            nxt_ptr   <= '0;
            src       <= '0;
            rem       <= '0;
            pal       <= 1'b0;
            id_hold   <= '0;
            frame_id  <= '0;
            beat      <= '0;
            burst_len <= '0;
        end else if (start) begin
            cur_ptr <= start_ptr[ADDR_W-1:2];
            beat    <= '0;
        end else begin
            unique case (state)
                ST_DESC_REQ: if (go) beat <= '0;
                ST_DESC_RCV: if (mem_rvalid) begin
                    beat <= beat + BL_W'(1);
                    unique case (beat[1:0])
                        2'd0: nxt_ptr <= mem_rdata[ADDR_W-1:2];
                        2'd1: src     <= mem_rdata[ADDR_W-1:2];
                        2'd2: id_hold <= mem_rdata;
                        default: begin
                            rem      <= mem_rdata[LEN_W-1:0];
                            pal      <= mem_rdata[PAL_FLAG_BIT];
                            frame_id <= id_hold;
                            if (zero_len) cur_ptr <= nxt_ptr;
                        end
                    endcase
                end
                ST_DATA_REQ: if (go) begin
                    burst_len <= blen;
                    beat      <= '0;
                end
                ST_DATA_RCV: if (mem_rvalid) begin
                    beat <= beat + BL_W'(1);
                    src  <= src + WA_W'(1);
                    rem  <= rem - LEN_W'(1);
                    if (xfer_end) cur_ptr <= nxt_ptr;
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_addr  = src;
        mem_len   = blen;
        wr_en     = 1'b0;
        desc_done = 1'b0;
        unique case (state)
            ST_DESC_REQ: begin
                mem_req  = 1'b1;
                mem_addr = cur_ptr;
                mem_len  = BL_W'(DESC_BEATS);
            end
            ST_DATA_REQ: mem_req = room;
            ST_DATA_RCV: begin
                wr_en     = mem_rvalid;
                desc_done = mem_rvalid && xfer_end;
            end
            default: ;
        endcase
    end

    assign wr_word = {pal, mem_rdata};
    assign clr     = start;

endmodule

// File: rtl/fbd_drain.sv
module fbd_drain (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        protect,
    input  logic        empty,
    input  logic [32:0] head,
    input  logic        pix_rd,
    output logic        pop,
    output logic        pix_valid,
    output logic [31:0] pix_data,
    output logic        pix_pal,
    output logic        underrun
);

    logic [32:0] last_word;

    assign pop = pix_rd && !empty;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_word <= '0;
            underrun  <= 1'b0;
        end else begin
            if (pop) last_word <= head;
            if (clr)                               underrun <= 1'b0;
            else if (pix_rd && empty && protect)   underrun <= 1'b1;
        end
    end

    assign pix_valid = !empty || protect;
    assign pix_data  = empty ? last_word[31:0] : head[31:0];
    assign pix_pal   = empty ? last_word[32]   : head[32];

endmodule

// File: rtl/fb_dma_fetch.sv
module fb_dma_fetch #(
    parameter int ADDR_W = 32,
    parameter int LEN_W = 24,
    parameter int BURST = 16,
    parameter int FIFO_DEPTH = 32,
    localparam int BL_W = $clog2(BURST + 1),
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] desc_ptr0,
    input  logic [ADDR_W-1:0] desc_ptr1,
    input  logic              ur_protect,
    output logic              mem_req,
    output logic [ADDR_W-3:0] mem_addr,
    output logic [BL_W-1:0]   mem_len,
    input  logic              mem_gnt,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    input  logic              pix_rd,
    output logic              pix_valid,
    output logic [31:0]       pix_data,
    output logic              pix_pal,
    output logic              underrun,
    output logic [31:0]       frame_id,
    output logic              desc_done,
    output logic [ADDR_W-1:0] dual_ptr
);

    logic             fifo_wr;
    logic [32:0]      fifo_wdata;
    logic             fifo_rd;
    logic [32:0]      fifo_head;
    logic             fifo_empty;
    logic [CNT_W-1:0] fifo_free;
    logic             fifo_clr;

    fbd_ctrl #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .BURST(BURST), .CNT_W(CNT_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .start_ptr(desc_ptr0),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_len(mem_len),
        .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .fifo_free(fifo_free), .wr_en(fifo_wr), .wr_word(fifo_wdata),
        .clr(fifo_clr), .frame_id(frame_id), .desc_done(desc_done)
    );

    fbd_fifo #(.W(33), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .clr(fifo_clr), .wr(fifo_wr),
        .wdata(fifo_wdata), .rd(fifo_rd), .rdata(fifo_head),
        .empty(fifo_empty), .free(fifo_free)
    );

    fbd_drain u_drain (
        .clk(clk), .rst_n(rst_n), .clr(fifo_clr), .protect(ur_protect),
        .empty(fifo_empty), .head(fifo_head), .pix_rd(pix_rd), .pop(fifo_rd),
        .pix_valid(pix_valid), .pix_data(pix_data), .pix_pal(pix_pal),
        .underrun(underrun)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     dual_ptr <= '0;
        else if (start) dual_ptr <= desc_ptr1;
    end

endmodule

// File: rtl/fbd_chk.sv
module fbd_chk #(
    parameter int ADDR_W = 32,
    parameter int BURST = 16,
    parameter int BL_W = 5,
    parameter int CNT_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              mem_req,
    input logic              mem_gnt,
    input logic [ADDR_W-3:0] mem_addr,
    input logic [BL_W-1:0]   mem_len,
    input logic              fifo_wr,
    input logic [CNT_W-1:0]  fifo_free,
    input logic              fifo_empty,
    input logic              ur_protect,
    input logic              pix_valid,
    input logic              underrun,
    input logic              desc_done
);

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_gnt && !start |=> mem_req && $stable(mem_addr) && $stable(mem_len));

    // R3
    burst_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_len != '0) && (mem_len <= BL_W'(BURST)));

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |-> fifo_free != '0);

    // R11
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underrun && !start |=> underrun);

    // R12
    no_protect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ur_protect && !underrun |=> !underrun);

    // R12
    empty_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_empty && !ur_protect |-> !pix_valid);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        desc_done |=> !desc_done);

endmodule

bind fb_dma_fetch fbd_chk #(
    .ADDR_W(ADDR_W), .BURST(BURST), .BL_W(BL_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .mem_req(mem_req),
    .mem_gnt(mem_gnt), .mem_addr(mem_addr), .mem_len(mem_len),
    .fifo_wr(fifo_wr), .fifo_free(fifo_free), .fifo_empty(fifo_empty),
    .ur_protect(ur_protect), .pix_valid(pix_valid), .underrun(underrun),
    .desc_done(desc_done)
);

// File: tb/sim_fb_dma_fetch.sv
`timescale 1ns/1ps
module sim_fb_dma_fetch;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] desc_ptr0 = '0;
    logic [31:0] desc_ptr1 = '0;
    logic        ur_protect = 1'b0;
    logic        mem_req;
    logic [29:0] mem_addr;
    logic [4:0]  mem_len;
    logic        mem_gnt = 1'b0;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        pix_rd = 1'b0;
    logic        pix_valid;
    logic [31:0] pix_data;
    logic        pix_pal;
    logic        underrun;
    logic [31:0] frame_id;
    logic        desc_done;
    logic [31:0] dual_ptr;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    fb_dma_fetch u0 (.*);

    logic [31:0] mem [512];
    int data_beats = 0;
    int pops = 0;
    bit bad_read = 1'b0;
    int done_log [64];
    int fid_log [64];
    int nd = 0;
    int nf = 0;
    logic [31:0] last_fid = '0;

    function automatic logic [31:0] fill(int i);
        return (32'(i) * 32'h9E37_79B1) ^ 32'h5A5A_0000;
    endfunction

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_start(logic [31:0] p0, logic [31:0] p1);
        @(negedge clk);
        #1 desc_ptr0 = p0; desc_ptr1 = p1; start = 1'b1;
        nd = 0; nf = 0; pops = 0; data_beats = 0;
        @(negedge clk);
        #1 start = 1'b0;
    endtask

    task automatic pop_expect(logic [31:0] ed, logic ep, string tag);
        @(negedge clk);
        while (!pix_valid) @(negedge clk);
        chk(pix_data == ed, tag, pix_data, ed);
        chk(pix_pal == ep, {tag, " pal"}, 32'(pix_pal), 32'(ep));
        #1 pix_rd = 1'b1;
        pops++;
        @(negedge clk);
        #1 pix_rd = 1'b0;
    endtask

    // Memory responder: grant after a short wait, beats with periodic gaps
    initial begin
        int wcnt, raddr, rleft, phase;
        bit busy;
        wcnt = 0; raddr = 0; rleft = 0; phase = 0; busy = 1'b0;
        forever begin
            @(negedge clk);
            if (start) begin
                busy = 1'b0; mem_gnt = 1'b0; mem_rvalid = 1'b0; wcnt = 0;
            end else if (busy) begin
                mem_gnt = 1'b0;
                if (rleft == 0) begin
                    busy = 1'b0; mem_rvalid = 1'b0;
                end else begin
                    phase++;
                    if (phase % 3 == 2) mem_rvalid = 1'b0;
                    else begin
                        mem_rvalid = 1'b1;
                        mem_rdata  = mem[raddr & 511];
                        if (raddr >= 'h80) data_beats++;
                        if (raddr >= 'h120 && raddr < 'h130) bad_read = 1'b1;
                        raddr++; rleft--;
                    end
                end
            end else begin
                mem_rvalid = 1'b0;
                if (mem_req) begin
                    if (wcnt == 2) begin
                        mem_gnt = 1'b1; busy = 1'b1; wcnt = 0; phase = 0;
                        raddr = int'(mem_addr); rleft = int'(mem_len);
                    end else wcnt++;
                end else wcnt = 0;
            end
        end
    end

    // Monitor of frame_id changes and completion pulses
    initial begin
        forever begin
            @(negedge clk);
            if (desc_done && nd < 64) begin done_log[nd] = int'(frame_id); nd++; end
            if (frame_id != last_fid) begin
                if (nf < 64) begin fid_log[nf] = int'(frame_id); nf++; end
                last_fid = frame_id;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 512; i++) mem[i] = fill(i);
        // colour-table descriptor at 0x100, frame at 0x110 (alternating)
        mem['h40] = 32'h110; mem['h41] = 32'h200; mem['h42] = 32'd7; mem['h43] = 32'h1000_0005;
        mem['h44] = 32'h100; mem['h45] = 32'h300; mem['h46] = 32'd9; mem['h47] = 32'h0100_0014;
        // self-looping true-colour frame at 0x140, zero-length lead-in at 0x150
        mem['h50] = 32'h140; mem['h51] = 32'h400; mem['h52] = 32'd3; mem['h53] = 32'h0000_0006;
        mem['h54] = 32'h140; mem['h55] = 32'h480; mem['h56] = 32'd4; mem['h57] = 32'h0000_0000;

        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(mem_req == 1'b0, "R1 mem_req", 32'(mem_req), 0);
        chk(pix_valid == 1'b0, "R1 pix_valid", 32'(pix_valid), 0);
        chk(underrun == 1'b0, "R1 underrun", 32'(underrun), 0);
        chk(desc_done == 1'b0, "R1 desc_done", 32'(desc_done), 0);
        chk(frame_id == 0, "R1 frame_id", frame_id, 0);

        // Alternating chain: R2 R3 R4 R5 R10
        do_start(32'h100, 32'hCAFE_0010);
        chk(dual_ptr == 32'hCAFE_0010, "R13 dual_ptr", dual_ptr, 32'hCAFE_0010);
        for (int rep = 0; rep < 2; rep++) begin
            for (int k = 0; k < 5; k++) pop_expect(fill('h80 + k), 1'b1, "R4 table word");
            for (int k = 0; k < 20; k++) begin
                pop_expect(fill('hC0 + k), 1'b0, "R3 frame word");
                if (rep == 0 && k == 4) begin
                    repeat (150) @(negedge clk);
                    chk(data_beats - pops <= 32, "R9 fetched minus popped",
                        32'(data_beats - pops), 32);
                end
            end
        end
        chk(nd >= 3, "R8 done count", 32'(nd), 3);
        for (int k = 0; k < nd; k++)
            chk(done_log[k] == ((k % 2 == 0) ? 7 : 9), "R8 done id", 32'(done_log[k]),
                (k % 2 == 0) ? 32'd7 : 32'd9);
        for (int k = 0; k < nf; k++)
            chk(fid_log[k] == ((k % 2 == 0) ? 7 : 9), "R7 frame id order", 32'(fid_log[k]),
                (k % 2 == 0) ? 32'd7 : 32'd9);

        // Zero-length lead-in then self-loop: R5 R6 R7 R12
        do_start(32'h150, 32'hBEEF_0020);
        chk(pix_valid == 1'b0, "R12 empty invalid", 32'(pix_valid), 0);
        #1 pix_rd = 1'b1;
        @(negedge clk);
        #1 pix_rd = 1'b0;
        chk(underrun == 1'b0, "R12 no underrun", 32'(underrun), 0);
        for (int rep = 0; rep < 3; rep++)
            for (int k = 0; k < 6; k++) pop_expect(fill('h100 + k), 1'b0, "R5 self loop word");
        chk(nf == 2, "R7 id change count", 32'(nf), 2);
        chk(fid_log[0] == 4, "R7 zero-length id", 32'(fid_log[0]), 4);
        chk(fid_log[1] == 3, "R7 looping id", 32'(fid_log[1]), 3);
        chk(bad_read == 1'b0, "R6 zero-length read", 32'(bad_read), 0);
        for (int k = 0; k < nd; k++)
            chk(done_log[k] == 3, "R8 no pulse for empty", 32'(done_log[k]), 3);

        // Restart mid-fetch with protection: R11, R2
        ur_protect = 1'b1;
        do_start(32'h100, 32'hCAFE_0030);
        chk(pix_valid == 1'b1, "R11 valid while empty", 32'(pix_valid), 1);
        chk(pix_data == fill('h105), "R11 repeat word", pix_data, fill('h105));
        chk(underrun == 1'b0, "R11 not yet set", 32'(underrun), 0);
        #1 pix_rd = 1'b1;
        @(negedge clk);
        #1 pix_rd = 1'b0;
        chk(underrun == 1'b1, "R11 set on empty pop", 32'(underrun), 1);
        chk(pix_data == fill('h105), "R11 word held", pix_data, fill('h105));
        ur_protect = 1'b0;
        for (int k = 0; k < 5; k++) pop_expect(fill('h80 + k), 1'b1, "R2 restart table word");
        for (int k = 0; k < 20; k++) pop_expect(fill('hC0 + k), 1'b0, "R2 restart frame word");
        chk(underrun == 1'b1, "R11 sticky", 32'(underrun), 1);

        do_start(32'h140, 32'h0000_7777);
        chk(underrun == 1'b0, "R11 cleared by start", 32'(underrun), 0);
        chk(dual_ptr == 32'h0000_7777, "R13 dual_ptr update", dual_ptr, 32'h7777);
        for (int k = 0; k < 6; k++) pop_expect(fill('h100 + k), 1'b0, "R5 direct loop word");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule